// File: doc/BRIEF.md
# Sequenced Colour Map Register Interface

This block holds a colour lookup table of 256 main entries plus 4 overlay entries, each an 8-bit red, green and blue triple. Software reaches it through a 32-bit register port with three word offsets. One offset sets an entry pointer. The other two carry colour bytes, one for the main table and one for the overlay table. Each entry is transferred as three accesses in a fixed order: red first, then green, then blue. After blue, the pointer moves to the next entry, so a whole palette can be streamed after setting the pointer once.

Colour bytes always travel in the top byte of the bus word. The overlay table is selected by the low two bits of the pointer. A second, independent port lets the video path fetch any of the 260 entries as one 24-bit colour, for example for the pixel and cursor pipelines.

The register port has no back-pressure. A read or write strobe is accepted in the cycle it is high. Read data comes back with a one-cycle valid pulse, which the requester must capture when it appears. The lookup port is combinational from the table contents.

Top module: `clut_seq_regs`

## Requirements
- R1: A legal write at byte offset 0 loads the entry pointer from data bits 31:24 and returns the colour phase to red.
- R2: A legal write at offset 4 stores data bits 31:24 into the current colour component of main entry [pointer]. The phase then steps red to green to blue.
- R3: A legal write at offset 12 stores into overlay entry 256 + pointer[1:0], using the same phase stepping. Main entry [pointer] is left unchanged.
- R4: After an access to the blue component, the pointer increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R5: A legal read, at any offset, returns the current component of main entry [pointer] in bits 31:24 with bits 23:0 zero. bus_rvalid is high exactly one cycle after the strobe. The read advances phase and pointer exactly as a write does, and the phase is shared between reads and writes.
- R6: After reset, every entry is black (all components 0) except entries 255, 256 and 258, which are white (all components 0xFF). Pointer and phase are both cleared.
- R7: Only full-word accesses are legal. An access with bus_be not equal to 4'b1111 has no effect and raises no bus_rvalid. A write at any offset other than 0, 4 or 12 has no effect.
- R8: lk_rgb returns entry [lk_idx] as {R[23:16], G[15:8], B[7:0]} for lk_idx 0..259, and 0 above 259. A value written to the table is visible on lk_rgb in the cycle after the write edge.
- R9: If bus_wr and bus_rd are high in the same cycle, the write takes effect and the read is dropped: there is no bus_rvalid and no extra phase step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte offset of the access |
| bus_be | input | 4 | Byte enables; only 4'b1111 is legal |
| bus_wdata | input | 32 | Write data; colour or pointer in bits 31:24 |
| bus_rdata | output | 32 | Read data, component in bits 31:24 |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| lk_idx | input | 9 | Video lookup entry number |
| lk_rgb | output | 24 | Video lookup colour |

## Verification
Main-table writes are streamed across several consecutive entries. This separates a correct pointer increment after blue from one that fires after every byte, and the pass across entry 255 shows the modulo wrap. Overlay writes use pointers with different low bits and a nonzero upper part. This shows that only bits 1:0 choose the overlay slot and that the main entry is left untouched.

Reads and writes are interleaved on one entry to show that the phase is shared. A pointer reload in the middle of a triple shows that the phase returns to red. Partial-enable accesses, an unused offset and a read/write collision are each followed by a normal write. Its landing place on the lookup port shows whether the ignored access moved any state.

// File: rtl/clut_pkg.sv
package clut_pkg;
  // colour component selected by the next bus access
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  function automatic phase_e next_phase(input phase_e p);
    unique case (p)
      PH_RED:  next_phase = PH_GRN;
      PH_GRN:  next_phase = PH_BLU;
      default: next_phase = PH_RED;
    endcase
  endfunction
endpackage

// File: rtl/clut_seq_ctrl.sv
module clut_seq_ctrl
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned BE_W      = 4,
  parameter int unsigned OFS_INDEX = 0,
  parameter int unsigned OFS_MAIN  = 4,
  parameter int unsigned OFS_OVL   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [IDX_W-1:0]  idx_byte,
  output logic [IDX_W-1:0]  idx_q,
  output phase_e            phase_q,
  output logic              col_we,
  output logic              col_ovl,
  output logic              rd_fire
);
  logic legal, idx_ld, step;

  assign legal   = &bus_be;
  assign idx_ld  = bus_wr && legal && (bus_addr == ADDR_W'(OFS_INDEX));
  assign col_ovl = (bus_addr == ADDR_W'(OFS_OVL));
  assign col_we  = bus_wr && legal &&
                   ((bus_addr == ADDR_W'(OFS_MAIN)) || col_ovl);
  assign rd_fire = bus_rd && !bus_wr && legal;
  assign step    = col_we || rd_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (idx_ld) begin
      idx_q   <= idx_byte;
      phase_q <= PH_RED;
    end else if (step) begin
      phase_q <= next_phase(phase_q);
      if (phase_q == PH_BLU) idx_q <= idx_q + 1'b1;
    end
  end

  // R1: pointer load returns phase to red
  a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ld |=> (idx_q == $past(idx_byte)) && (phase_q == PH_RED));

  // R2: red access moves to green, pointer held
  a_r2_red_to_green: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !idx_ld && phase_q == PH_RED) |=>
      (phase_q == PH_GRN) && $stable(idx_q));

  // R4: blue access wraps phase and bumps pointer
  a_r4_blue_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !idx_ld && phase_q == PH_BLU) |=>
      (phase_q == PH_RED) && (idx_q == IDX_W'($past(idx_q) + 1'b1)));

  // R7: partial-width access moves nothing
  a_r7_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> $stable(idx_q) && $stable(phase_q));
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int unsigned MAIN_N = 256,
  parameter int unsigned OVL_N  = 4,
  parameter int unsigned CW     = 8,
  localparam int unsigned TOTAL = MAIN_N + OVL_N,
  localparam int unsigned AW    = $clog2(TOTAL),
  localparam int unsigned IDX_W = $clog2(MAIN_N),
  localparam int unsigned RGB_W = 3 * CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  phase_e           wsel,
  input  logic [AW-1:0]    waddr,
  input  logic [CW-1:0]    wbyte,
  input  logic [IDX_W-1:0] bus_idx,
  input  phase_e           bus_sel,
  output logic [CW-1:0]    bus_comp,
  input  logic [AW-1:0]    lk_idx,
  output logic [RGB_W-1:0] lk_rgb
);
  logic [TOTAL-1:0][RGB_W-1:0] ent_rgb;

  for (genvar e = 0; e < TOTAL; e++) begin : g_ent
    localparam bit WHITE = (e == MAIN_N - 1) || (e == MAIN_N) || (e == MAIN_N + 2);
    localparam logic [CW-1:0] INIT = WHITE ? {CW{1'b1}} : {CW{1'b0}};
    logic [CW-1:0] r_q, g_q, b_q;
    logic hit;
    assign hit = we && (waddr == AW'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_q <= INIT;
        g_q <= INIT;
        b_q <= INIT;
      end else if (hit) begin
        unique case (wsel)
          PH_RED:  r_q <= wbyte;
          PH_GRN:  g_q <= wbyte;
          default: b_q <= wbyte;
        endcase
      end
    end
    assign ent_rgb[e] = {r_q, g_q, b_q};
  end

  logic [RGB_W-1:0] bus_ent;
  assign bus_ent = ent_rgb[bus_idx];

  always_comb begin
    unique case (bus_sel)
      PH_RED:  bus_comp = bus_ent[RGB_W-1 -: CW];
      PH_GRN:  bus_comp = bus_ent[2*CW-1 -: CW];
      default: bus_comp = bus_ent[CW-1:0];
    endcase
  end

  assign lk_rgb = (lk_idx < AW'(TOTAL)) ? ent_rgb[lk_idx] : '0;
endmodule

// File: rtl/clut_seq_regs.sv
module clut_seq_regs
  import clut_pkg::*;
#(
  parameter int unsigned MAIN_N    = 256,
  parameter int unsigned OVL_N     = 4,
  parameter int unsigned CW        = 8,
  parameter int unsigned DW        = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned OFS_INDEX = 0,
  parameter int unsigned OFS_MAIN  = 4,
  parameter int unsigned OFS_OVL   = 12,
  localparam int unsigned TOTAL = MAIN_N + OVL_N,
  localparam int unsigned AW    = $clog2(TOTAL),
  localparam int unsigned IDX_W = $clog2(MAIN_N),
  localparam int unsigned OVL_W = $clog2(OVL_N),
  localparam int unsigned BE_W  = DW / 8,
  localparam int unsigned RGB_W = 3 * CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  input  logic [AW-1:0]     lk_idx,
  output logic [RGB_W-1:0]  lk_rgb
);
  logic [IDX_W-1:0] idx_q;
  phase_e           phase_q;
  logic             col_we, col_ovl, rd_fire;
  logic [AW-1:0]    waddr;
  logic [CW-1:0]    bus_comp;

  clut_seq_ctrl #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BE_W(BE_W),
    .OFS_INDEX(OFS_INDEX), .OFS_MAIN(OFS_MAIN), .OFS_OVL(OFS_OVL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be),
    .idx_byte(bus_wdata[DW-1 -: IDX_W]),
    .idx_q(idx_q), .phase_q(phase_q),
    .col_we(col_we), .col_ovl(col_ovl), .rd_fire(rd_fire)
  );

  // overlay slot chosen by the low pointer bits
  assign waddr = col_ovl ? AW'(MAIN_N) + AW'(idx_q[OVL_W-1:0]) : AW'(idx_q);

  clut_store #(.MAIN_N(MAIN_N), .OVL_N(OVL_N), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(col_we), .wsel(phase_q), .waddr(waddr), .wbyte(bus_wdata[DW-1 -: CW]),
    .bus_idx(idx_q), .bus_sel(phase_q), .bus_comp(bus_comp),
    .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_fire;
      bus_rdata  <= rd_fire ? {bus_comp, {(DW-CW){1'b0}}} : '0;
    end
  end

  // R5: read strobe answered one cycle later
  a_r5_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && (&bus_be)) |=> bus_rvalid);

  // R9: collision drops the read
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_rvalid);
endmodule

// File: tb/clut_seq_regs_tb.sv
`timescale 1ns/1ps
module clut_seq_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0, bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [8:0]  lk_idx = '0;
  logic [23:0] lk_rgb;

  always #2 clk = ~clk;

  clut_seq_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [23:0] m [260];
  int midx = 0, mph = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void m_step();
    if (mph == 2) begin mph = 0; midx = (midx + 1) % 256; end
    else mph++;
  endfunction

  function automatic void m_store(input bit ovl, input logic [7:0] b);
    int t = ovl ? 256 + (midx % 4) : midx;
    case (mph)
      0: m[t][23:16] = b;
      1: m[t][15:8]  = b;
      default: m[t][7:0] = b;
    endcase
    m_step();
  endfunction

  function automatic logic [7:0] m_load();
    logic [7:0] b = (mph == 0) ? m[midx][23:16] : (mph == 1) ? m[midx][15:8] : m[midx][7:0];
    m_step();
    return b;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] b, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = {b, 24'h5A5A5A}; bus_be = be;
    @(negedge clk);
    bus_wr = 0; bus_be = 4'hF;
    if (be == 4'hF) begin
      if (a == 0) begin midx = b; mph = 0; end
      else if (a == 4) m_store(0, b);
      else if (a == 12) m_store(1, b);
    end
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a = 4);
    logic [7:0] e;
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    e = m_load();
    chk({req, " rvalid"}, {31'b0, bus_rvalid}, 32'd1);
    chk({req, " rdata"}, bus_rdata, {e, 24'h0});
  endtask

  task automatic lk_chk(input string req, input int i);
    lk_idx = 9'(i);
    #0.5;
    chk(req, {8'h0, lk_rgb}, {8'h0, (i < 260) ? m[i] : 24'h0});
  endtask

  task automatic t_reset();
    foreach (m[i]) m[i] = (i == 255 || i == 256 || i == 258) ? 24'hFFFFFF : 24'h0;
    @(negedge clk);
    foreach (m[i]) if (i % 37 == 0 || i >= 254) lk_chk("R6 reset entry", i);
    lk_chk("R8 out of range", 300);
    chk("R6 rvalid idle", {31'b0, bus_rvalid}, 32'd0);
    rd_chk("R6 pointer zero");
    midx = 0; mph = 0;
    wr(0, 8'd0);
  endtask

  task automatic t_main_stream();
    wr(0, 8'd5);
    for (int k = 0; k < 6; k++) wr(4, 8'(8'h10 + k));
    lk_chk("R2 entry 5", 5);
    lk_chk("R4 entry 6 after increment", 6);
    lk_chk("R2 entry 7 untouched", 7);
  endtask

  task automatic t_visible();
    wr(0, 8'd40);
    wr(4, 8'hC3);
    lk_chk("R8 visible next cycle", 40);
  endtask

  task automatic t_overlay();
    wr(0, 8'h42);
    for (int k = 0; k < 4; k++) wr(12, 8'(8'hA0 + k));
    lk_chk("R3 overlay 258", 258);
    lk_chk("R3 overlay 259", 259);
    lk_chk("R3 main 0x42 untouched", 8'h42);
    lk_chk("R3 main 0x43 untouched", 8'h43);
  endtask

  task automatic t_read();
    wr(0, 8'd5);
    rd_chk("R5 read red");
    rd_chk("R5 read green", 0);
    rd_chk("R5 read blue", 8);
    rd_chk("R5 read next entry red");
  endtask

  task automatic t_restart();
    wr(0, 8'd10);
    wr(4, 8'h77);
    wr(0, 8'd10);
    wr(4, 8'h88);
    lk_chk("R1 reload returns to red", 10);
  endtask

  task automatic t_wrap();
    wr(0, 8'd255);
    wr(4, 8'h01); wr(4, 8'h02); wr(4, 8'h03);
    wr(4, 8'h44);
    lk_chk("R4 entry 255", 255);
    lk_chk("R4 wrap to entry 0", 0);
  endtask

  task automatic t_ignored();
    wr(0, 8'd30);
    wr(4, 8'h11);
    wr(8, 8'hEE);
    wr(4, 8'hEE, 4'h7);
    wr(0, 8'd99, 4'hE);
    @(negedge clk);
    bus_rd = 1; bus_be = 4'hB; bus_addr = 4;
    @(negedge clk);
    bus_rd = 0; bus_be = 4'hF;
    chk("R7 partial read no rvalid", {31'b0, bus_rvalid}, 32'd0);
    wr(4, 8'h22);
    lk_chk("R7 ignored accesses", 30);
  endtask

  task automatic t_shared();
    wr(0, 8'd20);
    wr(4, 8'h31);
    rd_chk("R5 read shares phase");
    wr(4, 8'h33);
    lk_chk("R5 shared phase blue", 20);
  endtask

  task automatic t_collision();
    wr(0, 8'd50);
    @(negedge clk);
    bus_wr = 1; bus_rd = 1; bus_addr = 4; bus_wdata = 32'h9C000000;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    m_store(0, 8'h9C);
    chk("R9 read dropped", {31'b0, bus_rvalid}, 32'd0);
    wr(4, 8'h9D);
    lk_chk("R9 single step", 50);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_main_stream();
    t_visible();
    t_overlay();
    t_read();
    t_restart();
    t_wrap();
    t_ignored();
    t_shared();
    t_collision();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule